// File: doc/BRIEF.md
# Windowed Watchdog Timer with Prescaler

This block is a watchdog for a low-speed time base. A 12-bit counter counts down, one step per prescaled tick. If software fails to service it before it reaches zero, it raises a sticky underflow flag. It can also drive a system reset output low for a fixed number of clocks.

Servicing is accepted only inside a window. A service write carries a 16-bit key. If it arrives while the count is still above a programmable delta threshold, it is treated as a fault: the error flag is set, the counter is left alone, and the same reset pulse may follow. This catches software that keeps kicking the timer from inside a tight runaway loop.

The tick source is one of two clock-enable inputs, chosen by a select bit. Counting can be paused by a debug-halt input, and by a sleep input when configured to do so. The configuration fields that define the timeout can be frozen by a lock that only a dedicated unlock value releases. All access goes through a small word-wide write/read port with four addresses.

Top module: `winwdg_top`

## Requirements
- R1: While and just after reset, the count reads 0xFFF (read address 3), the status word reads 0 (read address 2), and `sys_rst_n` is high.
- R2: The prescaler field, control bits [14:12] = s, makes the count drop by one every 2^s enabled ticks. After a valid service, the first drop comes a full 2^s ticks later.
- R3: Control bit 17 selects the tick source: 0 uses `clk_en_rc`, 1 uses `clk_en_xtal`. Pulses on the unselected input have no effect on the count.
- R4: When a decrement takes the count from 1 to 0, status bit 0 (underflow) is set. The count then stays at 0 until a valid service or reset.
- R5: With control bit 15 (reset enable) set, an underflow or an early service drives `sys_rst_n` low for exactly 4 clocks, starting the cycle after the event. With bit 15 clear, `sys_rst_n` stays high.
- R6: A write of 0x5FA0 in bits [15:0] to write address 2, while the count is at or below the delta value (write/read address 1, bits [11:0]), loads the count with the reload value (control bits [11:0]).
- R7: The same keyed write while the count is above the delta value sets status bit 1 (error) and does not reload the count.
- R8: A write to address 2 with any other value in bits [15:0] is ignored: no reload, no error flag, no reset pulse.
- R9: Writing address 3 with any value other than 0x35CA in bits [15:0] sets the lock (status bit 2); writing 0x35CA clears it. While locked, writes leave the reload value, prescaler field, reset enable and delta value unchanged.
- R10: While `dbg_halt` is high, counting and the prescaler pause. `sleep_req` pauses them only when control bit 16 is set.
- R11: A cycle with `rd_en` high and `rd_addr` = 2 clears the underflow and error flags at the next clock edge. A flag that is set in that same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en_rc | input | 1 | Tick enable from the internal RC oscillator domain |
| clk_en_xtal | input | 1 | Tick enable from the external crystal domain |
| dbg_halt | input | 1 | Debug halt: pauses counting |
| sleep_req | input | 1 | Sleep indication: pauses counting when configured |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 delta, 2 service key, 3 lock |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe: clears flags when reading status |
| rd_addr | input | 2 | Read address: 0 control, 1 delta, 2 status, 3 count |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| sys_rst_n | output | 1 | Active-low system reset request |

## Verification
The hardest states to reach from the ports are the early-service fault and underflow. Both need the count parked at a chosen distance from the delta value. With the reset defaults, reaching zero would take thousands of ticks.

The stimulus therefore programs a small reload value and a divide-by-one prescaler, then services the timer so the count is known exactly. It next moves the delta value below the running count before issuing the keyed write. Underflow is reached by letting the short reload value run out, with and without the reset enable. Each case is then observed at the pulse length, the flags and the frozen count.

// File: rtl/winwdg_pkg.sv
package winwdg_pkg;

    localparam int CNT_W  = 12;
    localparam int PSC_W  = 3;
    localparam int KEY_W  = 16;
    localparam int PCNT_W = (1 << PSC_W) - 1;

    // control word bit positions
    localparam int CTRL_PSC_LSB = CNT_W;
    localparam int CTRL_RSTEN   = CNT_W + PSC_W;
    localparam int CTRL_SLEEP   = CNT_W + PSC_W + 1;
    localparam int CTRL_SRC     = CNT_W + PSC_W + 2;
    localparam int CTRL_W       = CNT_W + PSC_W + 3;

    typedef enum logic [1:0] {
        REG_CTRL      = 2'd0,
        REG_DELTA     = 2'd1,
        REG_KICK_STAT = 2'd2,
        REG_LOCK_CNT  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] delta;
        logic [PSC_W-1:0] psc;
        logic             rst_en;
        logic             stop_sleep;
        logic             src_sel;
    } cfg_t;

endpackage

// File: rtl/winwdg_regs.sv
module winwdg_regs
    import winwdg_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter logic [15:0] UNLOCK_KEY = 16'h35CA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg,
    output logic              lock
);

    typedef struct packed {
        cfg_t cfg;
        logic lock;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                REG_CTRL: begin
                    if (!st_q.lock) begin
                        st_d.cfg.reload = wr_data[CNT_W-1:0];
                        st_d.cfg.psc    = wr_data[CTRL_PSC_LSB +: PSC_W];
                        st_d.cfg.rst_en = wr_data[CTRL_RSTEN];
                    end
                    st_d.cfg.stop_sleep = wr_data[CTRL_SLEEP];
                    st_d.cfg.src_sel    = wr_data[CTRL_SRC];
                end
                REG_DELTA: begin
                    if (!st_q.lock) begin
                        st_d.cfg.delta = wr_data[CNT_W-1:0];
                    end
                end
                REG_LOCK_CNT: begin
                    st_d.lock = (wr_data[KEY_W-1:0] != UNLOCK_KEY);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg.reload     <= '1;
            st_q.cfg.delta      <= '1;
            st_q.cfg.psc        <= '0;
            st_q.cfg.rst_en     <= 1'b0;
            st_q.cfg.stop_sleep <= 1'b0;
            st_q.cfg.src_sel    <= 1'b0;
            st_q.lock           <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg  = st_q.cfg;
    assign lock = st_q.lock;

endmodule

// File: rtl/winwdg_tick.sv
module winwdg_tick
    import winwdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_rc,
    input  logic              clk_en_xtal,
    input  logic              dbg_halt,
    input  logic              sleep_req,
    input  cfg_t              cfg,
    input  logic              kick_ok,
    output logic              dec,
    output logic [PCNT_W-1:0] pcnt
);

    typedef struct packed {
        logic [PCNT_W-1:0] pcnt;
    } tick_st_t;

    tick_st_t          st_d, st_q;
    logic              src_tick;
    logic              frozen;
    logic              adv;
    logic [PCNT_W-1:0] limit;

    always_comb begin
        st_d     = st_q;
        dec      = 1'b0;
        src_tick = cfg.src_sel ? clk_en_xtal : clk_en_rc;
        frozen   = dbg_halt | (sleep_req & cfg.stop_sleep);
        adv      = src_tick & ~frozen;
        limit    = PCNT_W'((1 << cfg.psc) - 1);
        if (kick_ok) begin
            st_d.pcnt = '0;
        end else if (adv) begin
            if (st_q.pcnt >= limit) begin
                st_d.pcnt = '0;
                dec       = 1'b1;
            end else begin
                st_d.pcnt = st_q.pcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pcnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pcnt = st_q.pcnt;

endmodule

// File: rtl/winwdg_count.sv
module winwdg_count
    import winwdg_pkg::*;
#(
    parameter  int RST_HOLD = 4,
    localparam int HOLD_W   = $clog2(RST_HOLD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg,
    input  logic             kick_req,
    input  logic             dec,
    input  logic             clr_flags,
    output logic [CNT_W-1:0] cnt,
    output logic             kick_ok,
    output logic             early,
    output logic             uf_flag,
    output logic             err_flag,
    output logic             sys_rst_n
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              uf;
        logic              err;
        logic [HOLD_W-1:0] hold;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    uf_evt;

    always_comb begin
        st_d    = st_q;
        early   = kick_req && (st_q.cnt > cfg.delta);
        kick_ok = kick_req && !early;
        uf_evt  = dec && !kick_ok && (st_q.cnt == CNT_W'(1));

        if (kick_ok) begin
            st_d.cnt = cfg.reload;
        end else if (dec && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end

        st_d.uf  = uf_evt | (st_q.uf  & ~clr_flags);
        st_d.err = early  | (st_q.err & ~clr_flags);

        if ((uf_evt || early) && cfg.rst_en) begin
            st_d.hold = HOLD_W'(RST_HOLD);
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '1;
            st_q.uf   <= 1'b0;
            st_q.err  <= 1'b0;
            st_q.hold <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt       = st_q.cnt;
    assign uf_flag   = st_q.uf;
    assign err_flag  = st_q.err;
    assign sys_rst_n = (st_q.hold == '0);

endmodule

// File: rtl/winwdg_top.sv
module winwdg_top
    import winwdg_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          RST_HOLD   = 4,
    parameter logic [15:0] KICK_KEY   = 16'h5FA0,
    parameter logic [15:0] UNLOCK_KEY = 16'h35CA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_rc,
    input  logic              clk_en_xtal,
    input  logic              dbg_halt,
    input  logic              sleep_req,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              sys_rst_n
);

    cfg_t              cfg_w;
    logic              lock_w;
    logic              kick_req_w;
    logic              kick_ok_w;
    logic              early_w;
    logic              dec_w;
    logic              clr_w;
    logic              uf_w;
    logic              err_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [PCNT_W-1:0] pcnt_w;

    assign kick_req_w = wr_en && (reg_addr_e'(wr_addr) == REG_KICK_STAT)
                        && (wr_data[KEY_W-1:0] == KICK_KEY);
    assign clr_w      = rd_en && (reg_addr_e'(rd_addr) == REG_KICK_STAT);

    winwdg_regs #(
        .DATA_W     (DATA_W),
        .UNLOCK_KEY (UNLOCK_KEY)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg_w),
        .lock    (lock_w)
    );

    winwdg_tick tick_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_en_rc   (clk_en_rc),
        .clk_en_xtal (clk_en_xtal),
        .dbg_halt    (dbg_halt),
        .sleep_req   (sleep_req),
        .cfg         (cfg_w),
        .kick_ok     (kick_ok_w),
        .dec         (dec_w),
        .pcnt        (pcnt_w)
    );

    winwdg_count #(
        .RST_HOLD (RST_HOLD)
    ) count_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg_w),
        .kick_req  (kick_req_w),
        .dec       (dec_w),
        .clr_flags (clr_w),
        .cnt       (cnt_w),
        .kick_ok   (kick_ok_w),
        .early     (early_w),
        .uf_flag   (uf_w),
        .err_flag  (err_w),
        .sys_rst_n (sys_rst_n)
    );

    always_comb begin
        rd_data = '0;
        unique case (reg_addr_e'(rd_addr))
            REG_CTRL: begin
                rd_data[CNT_W-1:0]                = cfg_w.reload;
                rd_data[CTRL_PSC_LSB +: PSC_W]    = cfg_w.psc;
                rd_data[CTRL_RSTEN]               = cfg_w.rst_en;
                rd_data[CTRL_SLEEP]               = cfg_w.stop_sleep;
                rd_data[CTRL_SRC]                 = cfg_w.src_sel;
            end
            REG_DELTA:     rd_data[CNT_W-1:0] = cfg_w.delta;
            REG_KICK_STAT: rd_data[2:0]       = {lock_w, err_w, uf_w};
            REG_LOCK_CNT:  rd_data[CNT_W-1:0] = cnt_w;
            default: ;
        endcase
    end

endmodule

// File: rtl/winwdg_chk.sv
module winwdg_chk
    import winwdg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sys_rst_n,
    input logic              dbg_halt,
    input logic [CNT_W-1:0]  cnt,
    input cfg_t              cfg,
    input logic              lock,
    input logic              kick_ok,
    input logic              early,
    input logic              err,
    input logic [PCNT_W-1:0] pcnt
);

    // R6: a service inside the window loads the reload value
    a_r6_reload_loads: assert property (@(posedge clk) disable iff (!rst_n)
        kick_ok |=> (cnt == $past(cfg.reload)));

    // R7: early service raises the error flag
    a_r7_early_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        early |=> err);

    // R4: zero holds until serviced
    a_r4_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == '0) && !kick_ok) |=> (cnt == '0));

    // R5: a fault with reset enabled pulls the reset output low
    a_r5_fault_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (early && cfg.rst_en) |=> !sys_rst_n);

    // R9: locked fields do not move
    a_r9_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(cfg.delta) && $stable(cfg.reload)
                  && $stable(cfg.psc) && $stable(cfg.rst_en)));

    // R10: halt pauses prescaler and count
    a_r10_halt_pauses: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && !kick_ok) |=> ($stable(pcnt) && $stable(cnt)));

endmodule

bind winwdg_top winwdg_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_rst_n (sys_rst_n),
    .dbg_halt  (dbg_halt),
    .cnt       (cnt_w),
    .cfg       (cfg_w),
    .lock      (lock_w),
    .kick_ok   (kick_ok_w),
    .early     (early_w),
    .err       (err_w),
    .pcnt      (pcnt_w)
);

// File: tb/winwdg_tb_top.sv
`timescale 1ns/1ps
module winwdg_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en_rc = 1'b0;
    logic        clk_en_xtal = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        sleep_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = 2'd3;
    logic [31:0] rd_data;
    logic        sys_rst_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    winwdg_top dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en_rc(clk_en_rc), .clk_en_xtal(clk_en_xtal),
        .dbg_halt(dbg_halt), .sleep_req(sleep_req), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .sys_rst_n(sys_rst_n)
    );

    // behavioural reference model
    int m_cnt, m_pc, m_uf, m_err, m_lock, m_rel, m_delta, m_psc, m_rsten, m_sis, m_src, m_hold;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 4095; m_pc = 0; m_uf = 0; m_err = 0; m_lock = 0;
            m_rel = 4095; m_delta = 4095; m_psc = 0; m_rsten = 0;
            m_sis = 0; m_src = 0; m_hold = 0;
        end else begin
            int tk, adv, kreq, kok, erl, dcr, ufe, clr, nc;
            tk   = m_src ? clk_en_xtal : clk_en_rc;
            adv  = tk && !dbg_halt && !(sleep_req && m_sis);
            kreq = wr_en && wr_addr == 2 && wr_data[15:0] == 16'h5FA0;
            erl  = kreq && (m_cnt > m_delta);
            kok  = kreq && !erl;
            clr  = rd_en && rd_addr == 2;
            dcr  = 0;
            if (kok) m_pc = 0;
            else if (adv) begin
                if (m_pc >= (1 << m_psc) - 1) begin m_pc = 0; dcr = 1; end
                else m_pc = m_pc + 1;
            end
            ufe = dcr && !kok && m_cnt == 1;
            nc = m_cnt;
            if (kok) nc = m_rel;
            else if (dcr && m_cnt > 0) nc = m_cnt - 1;
            m_uf  = ufe || (m_uf && !clr);
            m_err = erl || (m_err && !clr);
            if ((ufe || erl) && m_rsten) m_hold = 4;
            else if (m_hold > 0) m_hold = m_hold - 1;
            if (wr_en) begin
                if (wr_addr == 0) begin
                    if (!m_lock) begin
                        m_rel = int'(wr_data[11:0]); m_psc = int'(wr_data[14:12]);
                        m_rsten = int'(wr_data[15]);
                    end
                    m_sis = int'(wr_data[16]); m_src = int'(wr_data[17]);
                end else if (wr_addr == 1) begin
                    if (!m_lock) m_delta = int'(wr_data[11:0]);
                end else if (wr_addr == 3) begin
                    m_lock = (wr_data[15:0] != 16'h35CA);
                end
            end
            m_cnt = nc;
        end
    end

    function automatic int model_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_rel | (m_psc << 12) | (m_rsten << 15) | (m_sis << 16) | (m_src << 17);
            2'd1: return m_delta;
            2'd2: return m_uf | (m_err << 1) | (m_lock << 2);
            default: return m_cnt;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock, then compare against the model at the falling edge
    task automatic cyc();
        @(negedge clk);
        if (rst_n) begin
            chk("model sys_rst_n", int'(sys_rst_n), (m_hold == 0) ? 1 : 0);
            chk("model rd_data", int'(rd_data), model_rd(rd_addr));
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic peek(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
        rd_addr = 2'd3;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        clk_en_rc = 1'b1;
        repeat (3) cyc();
        peek(2'd3, v); chk("R1 count at reset", v, 12'hFFF);
        peek(2'd2, v); chk("R1 status at reset", v, 0);
        chk("R1 sys_rst_n at reset", int'(sys_rst_n), 1);
        rst_n = 1'b1;
        cyc();

        // reload 20, divide by 1, no reset enable
        wr(2'd0, 32'd20);
        wr(2'd2, 32'h5FA0);
        peek(2'd3, v); chk("R6 reload in window", v, 20);

        // R2: divide by 4
        wr(2'd0, 32'd20 | (32'd2 << 12));
        wr(2'd2, 32'h5FA0);
        repeat (8) cyc();
        peek(2'd3, v); chk("R2 divide by 4 after 8 ticks", v, 18);

        // R3: source select to crystal, crystal idle
        clk_en_xtal = 1'b0;
        wr(2'd0, 32'd20 | (32'd2 << 12) | (32'd1 << 17));
        wr(2'd2, 32'h5FA0);
        repeat (10) cyc();
        peek(2'd3, v); chk("R3 unselected rc ignored", v, 20);
        clk_en_xtal = 1'b1; clk_en_rc = 1'b0;
        repeat (4) cyc();
        peek(2'd3, v); chk("R3 crystal ticks counted", v, 19);
        clk_en_rc = 1'b1;

        // R10: halt and sleep
        wr(2'd2, 32'h5FA0);
        dbg_halt = 1'b1;
        repeat (10) cyc();
        peek(2'd3, v); chk("R10 halt pauses", v, 20);
        dbg_halt = 1'b0;
        sleep_req = 1'b1;
        repeat (4) cyc();
        peek(2'd3, v); chk("R10 sleep ignored without option", v, 19);
        wr(2'd0, 32'd20 | (32'd2 << 12) | (32'd1 << 17) | (32'd1 << 16));
        wr(2'd2, 32'h5FA0);
        repeat (8) cyc();
        peek(2'd3, v); chk("R10 sleep pauses with option", v, 20);
        sleep_req = 1'b0;

        // R7 and R5: early service with reset enable
        wr(2'd0, 32'd20 | (32'd1 << 15));
        wr(2'd2, 32'h5FA0);
        wr(2'd1, 32'd5);
        wr(2'd2, 32'h5FA0);
        peek(2'd2, v); chk("R7 error flag", v & 2, 2);
        peek(2'd3, v); chk("R7 no reload on early service", v, 18);
        chk("R5 reset asserted", int'(sys_rst_n), 0);
        repeat (3) cyc();
        chk("R5 reset still low at 4th clock", int'(sys_rst_n), 0);
        cyc();
        chk("R5 reset released after 4 clocks", int'(sys_rst_n), 1);

        // R11: read clears flags
        rd_addr = 2'd2; rd_en = 1'b1;
        cyc();
        rd_en = 1'b0; rd_addr = 2'd3;
        peek(2'd2, v); chk("R11 flags cleared by read", v & 3, 0);

        // R8: wrong key
        wr(2'd2, 32'h0000_1234);
        peek(2'd2, v); chk("R8 wrong key no error", v & 2, 0);
        chk("R8 wrong key no reset", int'(sys_rst_n), 1);
        for (int i = 0; i < 40; i++) begin
            peek(2'd3, v);
            if (v <= 4) break;
            cyc();
        end
        wr(2'd2, 32'h0000_AAAA);
        peek(2'd3, v); chk("R8 wrong key no reload", (v <= 4) ? 1 : 0, 1);
        wr(2'd2, 32'h5FA0);
        peek(2'd3, v); chk("R6 reload at low count", v, 20);

        // R4: underflow with reset
        repeat (20) cyc();
        peek(2'd3, v); chk("R4 count reached zero", v, 0);
        peek(2'd2, v); chk("R4 underflow flag", v & 1, 1);
        chk("R5 reset on underflow", int'(sys_rst_n), 0);
        repeat (5) cyc();
        peek(2'd3, v); chk("R4 count holds zero", v, 0);

        // R5: no reset when disabled
        wr(2'd0, 32'd20);
        wr(2'd2, 32'h5FA0);
        repeat (21) cyc();
        peek(2'd3, v); chk("R4 zero again", v, 0);
        chk("R5 no reset when disabled", int'(sys_rst_n), 1);

        // R9: lock
        wr(2'd3, 32'd0);
        peek(2'd2, v); chk("R9 lock set", (v >> 2) & 1, 1);
        wr(2'd1, 32'd9);
        peek(2'd1, v); chk("R9 delta locked", v, 5);
        wr(2'd0, 32'd7 | (32'd1 << 15));
        peek(2'd0, v); chk("R9 reload locked", v & 32'hFFF, 20);
        chk("R9 reset enable locked", (v >> 15) & 1, 0);
        wr(2'd3, 32'h35CA);
        peek(2'd2, v); chk("R9 lock cleared", (v >> 2) & 1, 0);
        wr(2'd1, 32'd9);
        peek(2'd1, v); chk("R9 delta writable after unlock", v, 9);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule